// File: doc/BRIEF.md
# Scanline Area Fill Unit

The unit takes a stream of 16-bit destination words and fills the area between edge bits along each row. Words arrive in order along a row and one word may be presented per clock. A row-start flag marks the first word of each row. Bits inside a word are handled from the least significant end toward the most significant end, which is the order a bottom-up, right-to-left traversal produces. A running fill flag is carried from one bit to the next and from one word to the next. It is reloaded from a programmable start value whenever a new row begins. The unit works on the destination stream alone and needs no source data.

There are two fill modes. In exclusive mode each set edge bit flips the fill flag and is not kept on its own, so the output bit is the flag after the flip. In inclusive mode the output bit is the OR of the edge bit and the flag before the flip, so the region is filled solid and both of its bounding edges stay set. If both enables are set, inclusive mode is used. If neither is set, words pass through unchanged. Each result is computed combinationally and leaves through a register, one cycle after its input word.

The carried flag is held in a two-state machine, `ST_OUTSIDE` and `ST_INSIDE`. On each accepted word the state takes one of three transitions. *Enter* goes from outside to inside. *Leave* goes from inside to outside. *Stay* keeps the state when the word holds an even number of edges, when the word is in pass mode, or when no word is accepted. When the row-start flag is set, the start value replaces the held state before the first bit of that word is processed.

Top module: `scan_fill`

## Requirements
- R1: While reset is asserted, and right after it, `out_valid` is 0, `out_word` is 16'h0000 and the carried fill state is `ST_OUTSIDE`.
- R2: A word accepted with `in_valid`=1 at a clock edge appears on `out_word` with `out_valid`=1 after that same edge. A cycle with `in_valid`=0 gives `out_valid`=0, leaves `out_word` unchanged and leaves the fill state unchanged.
- R3: Exclusive mode (`excl_en`=1, `incl_en`=0): bits are processed from bit 0 up to bit 15. Each set input bit flips the fill flag, and output bit i equals the flag after bit i has been processed.
- R4: Inclusive mode (`incl_en`=1): output bit i equals input bit i OR the flag before bit i is processed. Each set input bit then flips the flag.
- R5: When `incl_en` and `excl_en` are both 1, the unit behaves exactly as in inclusive mode.
- R6: When both enables are 0, `out_word` equals the input word, and the fill state carried to the next word is unchanged.
- R7: When `in_row_start`=1, the flag that bit 0 of the word sees is `carry_in` (1 means inside), whatever state was held before.
- R8: When `in_row_start`=0, bit 0 of the word sees the flag left after bit 15 of the previous accepted word. This holds even across cycles with `in_valid`=0.
- R9: `carry_in` has no effect on a word presented with `in_row_start`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input word is presented this cycle |
| in_row_start | input | 1 | The word is the first of a new row |
| in_word | input | 16 | Destination word carrying the edge bits |
| incl_en | input | 1 | Inclusive fill enable |
| excl_en | input | 1 | Exclusive fill enable |
| carry_in | input | 1 | Fill flag loaded at the start of each row |
| out_valid | output | 1 | `out_word` holds a new result |
| out_word | output | 16 | Filled word |

## Verification
The bench goes after these cases:

- **Edge pair inside one word.** The exclusive and inclusive results differ only on the upper edge bit. A unit that swapped the old and new flag would light up the wrong edge.
- **Edge in bit 0 and bit 15.** This exposes a reversed bit order or an off-by-one in the chain. Either fault would leave one end of the word unfilled.
- **Flag across word boundaries.** The flag is carried across words, across idle cycles and across pass-through words. A unit that reloaded too often, or that let pass mode disturb the flag, would emit a clear word where a solid one is due.
- **Both enables set and a stale `carry_in`.** With both enables set, a design with the wrong priority produces the exclusive pattern. With `carry_in` changed mid-row, a design that sampled it on every word would change a row it should not touch.

// File: rtl/scan_fill_pkg.sv
package scan_fill_pkg;

    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,
        MODE_EXCL = 2'd1,
        MODE_INCL = 2'd2
    } fill_mode_e;

    typedef enum logic {
        ST_OUTSIDE = 1'b0,
        ST_INSIDE  = 1'b1
    } fill_state_e;

endpackage

// File: rtl/scan_fill_mode_dec.sv
module scan_fill_mode_dec
    import scan_fill_pkg::*;
(
    input  logic       incl_en,
    input  logic       excl_en,
    output fill_mode_e mode
);

    // Inclusive has priority over exclusive.
    always_comb begin
        if (incl_en)      mode = MODE_INCL;
        else if (excl_en) mode = MODE_EXCL;
        else              mode = MODE_PASS;
    end

endmodule

// File: rtl/scan_fill_word_core.sv
module scan_fill_word_core
    import scan_fill_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  fill_mode_e       mode,
    input  logic             start_flag,
    input  logic [WIDTH-1:0] edges,
    output logic [WIDTH-1:0] filled,
    output logic             end_flag
);

    // chain[i] is the flag seen by bit i; chain[WIDTH] is the flag after the word.
    logic [WIDTH:0] chain;

    assign chain[0] = start_flag;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic flipped;

        assign flipped      = chain[b] ^ edges[b];
        assign chain[b + 1] = flipped;

        always_comb begin
            unique case (mode)
                MODE_INCL: filled[b] = edges[b] | chain[b];
                MODE_EXCL: filled[b] = flipped;
                default:   filled[b] = edges[b];
            endcase
        end
    end

    // A pass-through word leaves the carried flag alone.
    assign end_flag = (mode == MODE_PASS) ? start_flag : chain[WIDTH];

endmodule

// File: rtl/scan_fill.sv
module scan_fill
    import scan_fill_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_row_start,
    input  logic [WIDTH-1:0] in_word,
    input  logic             incl_en,
    input  logic             excl_en,
    input  logic             carry_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_word
);

    localparam logic [WIDTH-1:0] ZERO_WORD = '0;

    fill_mode_e       mode;
    fill_state_e      fill_q;
    fill_state_e      fill_d;
    logic             start_flag;
    logic             end_flag;
    logic [WIDTH-1:0] filled;

    scan_fill_mode_dec u_mode (
        .incl_en (incl_en),
        .excl_en (excl_en),
        .mode    (mode)
    );

    // Reload from carry_in at a row start, otherwise continue the held state.
    assign start_flag = in_row_start ? carry_in : (fill_q == ST_INSIDE);

    scan_fill_word_core #(.WIDTH(WIDTH)) u_core (
        .mode       (mode),
        .start_flag (start_flag),
        .edges      (in_word),
        .filled     (filled),
        .end_flag   (end_flag)
    );

    // Transitions: enter, leave, or stay.
    always_comb begin
        fill_d = fill_q;
        if (in_valid) begin
            unique case (fill_q)
                ST_OUTSIDE: fill_d = end_flag ? ST_INSIDE : ST_OUTSIDE;
                ST_INSIDE:  fill_d = end_flag ? ST_INSIDE : ST_OUTSIDE;
                default:    fill_d = ST_OUTSIDE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= ST_OUTSIDE;
        else        fill_q <= fill_d;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= ZERO_WORD;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_word <= filled;
        end
    end

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !incl_en && !excl_en) |=> (out_word == $past(in_word))); // R6

    AST_PASS_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_row_start && !incl_en && !excl_en) |=> (fill_q == $past(fill_q))); // R6

    AST_INCL_KEEPS_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && incl_en) |=> ((out_word & $past(in_word)) == $past(in_word))); // R4

    AST_EXCL_TOP_IS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && excl_en && !incl_en) |=> (out_word[WIDTH-1] == (fill_q == ST_INSIDE))); // R3

    AST_ROW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_row_start && excl_en && !incl_en)
            |=> (out_word[0] == ($past(carry_in) ^ $past(in_word[0])))); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_word) && fill_q == $past(fill_q))); // R2

endmodule

// File: tb/tb_scan_fill.sv
`timescale 1ns/1ps
module tb_scan_fill;

    localparam int W = 16;
    localparam int NV = 12;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_row_start;
    logic [W-1:0] in_word;
    logic         incl_en;
    logic         excl_en;
    logic         carry_in;
    logic         out_valid;
    logic [W-1:0] out_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    scan_fill #(.WIDTH(W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_row_start (in_row_start),
        .in_word      (in_word),
        .incl_en      (incl_en),
        .excl_en      (excl_en),
        .carry_in     (carry_in),
        .out_valid    (out_valid),
        .out_word     (out_word)
    );

    // Vector layout: {row_start, incl, excl, carry_in, word[15:0], expected[15:0]}
    localparam logic [35:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b1, 1'b0, 16'h0810, 16'h07F0}, // R3 edge pair, exclusive
        {1'b1, 1'b1, 1'b0, 1'b0, 16'h0810, 16'h0FF0}, // R4 edge pair, inclusive
        {1'b1, 1'b0, 1'b1, 1'b1, 16'h0000, 16'hFFFF}, // R7 reload inside
        {1'b0, 1'b0, 1'b1, 1'b0, 16'h0100, 16'h00FF}, // R8 R9 carried flag, carry_in ignored
        {1'b1, 1'b1, 1'b1, 1'b0, 16'h8001, 16'hFFFF}, // R5 both enables
        {1'b1, 1'b0, 1'b0, 1'b0, 16'hA5C3, 16'hA5C3}, // R6 pass through
        {1'b1, 1'b0, 1'b1, 1'b0, 16'h0001, 16'hFFFF}, // R3 edge at bit 0
        {1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h1234}, // R6 pass mid-row
        {1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'hFFFF}, // R6 R8 flag kept through pass
        {1'b0, 1'b1, 1'b0, 1'b1, 16'h0002, 16'h0003}, // R4 R9 inclusive carried
        {1'b1, 1'b1, 1'b0, 1'b1, 16'h0000, 16'hFFFF}, // R7 inclusive reload
        {1'b1, 1'b0, 1'b1, 1'b0, 16'h0003, 16'h0001}  // R3 adjacent edges
    };

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic rs, input logic inc, input logic exc,
                         input logic cin, input logic [W-1:0] w);
        in_valid = 1'b1; in_row_start = rs; incl_en = inc; excl_en = exc;
        carry_in = cin; in_word = w;
    endtask

    task automatic idle();
        in_valid = 1'b0; in_row_start = 1'b0; in_word = '0;
        incl_en = 1'b0; excl_en = 1'b0; carry_in = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        finish_run();
    end

    initial begin
        logic [W-1:0] held;
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid in reset", {15'd0, out_valid}, 16'h0);
        check(out_word == '0, "R1 out_word in reset", out_word, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_word == '0, "R1 after reset", out_word, 16'h0);

        // R1: the held state starts outside, so an exclusive word with no edges stays clear.
        drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0000);
        @(negedge clk);
        check(out_word == 16'h0000, "R1 initial fill state", out_word, 16'h0000);

        // Vector table, back to back.
        drive(VEC[0][35], VEC[0][34], VEC[0][33], VEC[0][32], VEC[0][31:16]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check(out_valid == 1'b1, "R2 valid latency", {15'd0, out_valid}, 16'h1);
            check(out_word == VEC[i][15:0], $sformatf("vector %0d (R3-R9 table)", i),
                  out_word, VEC[i][15:0]);
            if (i + 1 < NV)
                drive(VEC[i+1][35], VEC[i+1][34], VEC[i+1][33], VEC[i+1][32], VEC[i+1][31:16]);
            else
                idle();
        end

        // R2 idle cycles hold the output.
        held = out_word;
        @(negedge clk);
        check(out_valid == 1'b0, "R2 valid drops", {15'd0, out_valid}, 16'h0);
        check(out_word == held, "R2 word held", out_word, held);

        // R8 flag survives idle gaps.
        drive(1'b1, 1'b0, 1'b1, 1'b1, 16'h0000);
        @(negedge clk);
        check(out_word == 16'hFFFF, "R7 reload before gap", out_word, 16'hFFFF);
        idle();
        repeat (3) @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 16'h0000);
        @(negedge clk);
        check(out_word == 16'hFFFF, "R8 flag across idle gap", out_word, 16'hFFFF);

        // R3 edge in the top bit only.
        drive(1'b1, 1'b0, 1'b1, 1'b0, 16'h8000);
        @(negedge clk);
        check(out_word == 16'h8000, "R3 edge at bit 15", out_word, 16'h8000);

        // R4 inclusive edge at bit 15 with inside flag.
        drive(1'b1, 1'b1, 1'b0, 1'b1, 16'h8000);
        @(negedge clk);
        check(out_word == 16'hFFFF, "R4 inclusive top edge", out_word, 16'hFFFF);
        idle();

        // R1 reset in mid-run.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_word == '0, "R1 reset mid-run", out_word, 16'h0);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0000);
        @(negedge clk);
        check(out_word == 16'h0000, "R1 state cleared by reset", out_word, 16'h0000);
        idle();
        @(negedge clk);

        finish_run();
    end

endmodule